// File: doc/BRIEF.md
# Variable-Frequency Tick Generator

This block is a numerically controlled oscillator that runs in a fixed reference clock domain. A 16-bit phase accumulator adds a step on every reference cycle. The step comes from a 16-bit control word. The most significant accumulator bit is the output level. The output frequency is the step divided by 65536, times the reference frequency. Besides the level, the block gives a one-cycle tick on every rising edge of that level. Downstream logic can use the tick as a clock enable and so stay in the reference domain.

Software loads the control word one byte at a time. The upper byte is only staged. Writing the lower byte commits the staged upper byte and the new lower byte together, so the running frequency never sees half of a new word. A control word below 32768 is used as the step as it is. Any larger word is replaced by its 16-bit two's complement.

The run input drives a two-state machine. In the HALTED state the accumulator is held at zero and both outputs stay low. In the RUNNING state the accumulator advances. The HALTED to RUNNING transition (start) happens on any edge with run high. The RUNNING to HALTED transition (stop) happens on any edge with run low.

Top module: `nco_tick_gen`

## Requirements
- R1: After reset, level_out and tick_out are 0 and the committed control word is 0, so the outputs stay low even with run_en high until a word is loaded.
- R2: A wr_hi pulse only stages wr_byte as the upper byte and leaves the running frequency unchanged. A wr_lo pulse commits {staged upper byte, wr_byte} as the control word at that clock edge. If both pulses come in the same cycle, the commit uses the previously staged upper byte.
- R3: The step is the control word when bit 15 of the word is 0. Otherwise the step is (65536 - word) mod 65536, so 0xE000 runs at the same rate as 0x2000.
- R4: While run_en is high, the accumulator grows by the step, modulo 65536, at each edge, and level_out equals accumulator bit 15. The step used is the word committed before that edge.
- R5: tick_out is high for exactly one cycle each time level_out goes from 0 to 1, and in the same cycle.
- R6: For a control word that is a power of two, level_out is a square wave with exactly 50% high time over whole periods.
- R7: An edge with run_en low clears the accumulator to 0, so both outputs are 0 after that edge. Running resumes from phase 0.
- R8: Over N cycles from phase 0, where N is a multiple of 65536/step, the tick count is N*step/65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run/start; low holds the accumulator at zero |
| wr_hi | input | 1 | Stage wr_byte as upper control byte |
| wr_lo | input | 1 | Commit {staged upper, wr_byte} as control word |
| wr_byte | input | 8 | Byte write data |
| level_out | output | 1 | Square-wave level (accumulator MSB) |
| tick_out | output | 1 | One-cycle pulse on each rising level |

## Verification
The assertions take for granted that the write strobes and run_en are synchronous to the reference clock and stable around the edge. They also assume the effective step never exceeds 32768, which the word-to-step mapping ensures for any 16-bit word. The stimulus drives every input on the falling edge. It draws words from a pool that covers 0x8000, 0xFFFF, 0x0001 and powers of two and their negatives, so every step stays legal. Upper-only writes, simultaneous strobes and run drops are mixed in at random.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } nco_state_t;
endpackage

// File: rtl/nco_word_loader.sv
module nco_word_loader #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wr_byte,
    output logic [2*BYTE_W-1:0]   cword
);
    logic [BYTE_W-1:0]   hi_stage_q;
    logic [2*BYTE_W-1:0] cword_q;

    // Upper byte is staged only; lower byte write commits both halves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
            cword_q    <= '0;
        end else begin
            if (wr_lo) cword_q    <= {hi_stage_q, wr_byte};
            if (wr_hi) hi_stage_q <= wr_byte;
        end
    end

    assign cword = cword_q;

    a_r2_hi_only_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo) |=> $stable(cword_q));
    a_r2_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cword_q[BYTE_W-1:0] == $past(wr_byte)));
endmodule

// File: rtl/nco_step_decode.sv
module nco_step_decode #(
    parameter int CW_W = 16
) (
    input  logic [CW_W-1:0] cword,
    output logic [CW_W-1:0] step
);
    localparam logic [CW_W-1:0] HALF_RANGE = {1'b1, {(CW_W-1){1'b0}}};

    // Words with the top bit set run at their two's-complement magnitude.
    always_comb begin
        if (cword[CW_W-1]) step = (~cword) + {{(CW_W-1){1'b0}}, 1'b1};
        else               step = cword;
    end

    always_comb begin
        a_r3_step_bound: assert (step <= HALF_RANGE);
    end
endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum
    import nco_pkg::*;
#(
    parameter int CW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic [CW_W-1:0] step,
    output logic            level_out,
    output logic            tick_out
);
    localparam int MSB = CW_W - 1;

    nco_state_t      state_q, state_d;
    logic [CW_W-1:0] acc_q, acc_d;
    logic            tick_q, tick_d;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            acc_q   <= '0;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            tick_q  <= tick_d;
        end
    end

    // Next-state process: start and stop transitions follow run_en.
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        tick_d  = 1'b0;
        unique case (state_q)
            ST_HALTED: begin
                acc_d = '0;
                if (run_en) begin
                    state_d = ST_RUNNING;
                    acc_d   = step;
                    tick_d  = step[MSB];
                end
            end
            ST_RUNNING: begin
                if (!run_en) begin
                    state_d = ST_HALTED;
                    acc_d   = '0;
                end else begin
                    acc_d  = acc_q + step;
                    tick_d = !acc_q[MSB] && acc_d[MSB];
                end
            end
            default: begin
                state_d = ST_HALTED;
                acc_d   = '0;
            end
        endcase
    end

    // Output process.
    always_comb begin
        level_out = (state_q == ST_RUNNING) && acc_q[MSB];
        tick_out  = tick_q;
    end

    a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |=> !tick_out);
    a_r5_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> level_out);
    a_r5_rise_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_out ##1 level_out) |-> tick_out);
    a_r7_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!level_out && !tick_out && acc_q == '0));
endmodule

// File: rtl/nco_tick_gen.sv
module nco_tick_gen #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              level_out,
    output logic              tick_out
);
    localparam int CW_W = 2 * BYTE_W;

    logic [CW_W-1:0] cword;
    logic [CW_W-1:0] step;

    nco_word_loader #(.BYTE_W(BYTE_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_byte (wr_byte),
        .cword   (cword)
    );

    nco_step_decode #(.CW_W(CW_W)) u_decode (
        .cword (cword),
        .step  (step)
    );

    nco_phase_accum #(.CW_W(CW_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .step      (step),
        .level_out (level_out),
        .tick_out  (tick_out)
    );
endmodule

// File: tb/nco_tick_gen_tb.sv
module nco_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       level_out, tick_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R4";

    logic [15:0] m_acc, m_cw;
    logic [7:0]  m_hi;
    logic        m_tick;
    int          tick_cnt, high_cnt;

    always #2.5 clk = ~clk;

    nco_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_byte(wr_byte), .level_out(level_out), .tick_out(tick_out)
    );

    function automatic logic [15:0] step_of(input logic [15:0] w);
        return w[15] ? 16'(32'd65536 - 32'(w)) : w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic en, input logic hi, input logic lo, input logic [7:0] b);
        logic [15:0] nxt;
        @(negedge clk);
        run_en = en; wr_hi = hi; wr_lo = lo; wr_byte = b;
        @(posedge clk); #1;
        if (!en) begin
            m_acc = 16'h0; m_tick = 1'b0;
        end else begin
            nxt = m_acc + step_of(m_cw);
            m_tick = !m_acc[15] && nxt[15];
            m_acc = nxt;
        end
        if (lo) m_cw = {m_hi, b};
        if (hi) m_hi = b;
        check({tag, " level"}, {31'd0, level_out}, {31'd0, m_acc[15]});
        check({tag, " tick"}, {31'd0, tick_out}, {31'd0, m_tick});
        if (tick_out) tick_cnt++;
        if (level_out) high_cnt++;
    endtask

    task automatic load(input logic [15:0] w, input logic en);
        cyc(en, 1'b1, 1'b0, w[15:8]);
        cyc(en, 1'b0, 1'b1, w[7:0]);
    endtask

    task automatic run(input int n);
        tick_cnt = 0; high_cnt = 0;
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        logic [15:0] pool [8];
        pool[0] = 16'h8000; pool[1] = 16'hFFFF; pool[2] = 16'h0001; pool[3] = 16'h2000;
        pool[4] = 16'hE000; pool[5] = 16'h1234; pool[6] = 16'h7FFF; pool[7] = 16'h0400;
        m_acc = '0; m_cw = '0; m_hi = '0; m_tick = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 level at reset", {31'd0, level_out}, 32'd0);
        check("R1 tick at reset", {31'd0, tick_out}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; run(20);
        check("R1 no ticks with zero word", tick_cnt, 0);

        // R2: upper byte alone does not change rate
        tag = "R2"; load(16'h2000, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 8'h40);
        run(63);
        check("R2 hi-only write ignored, ticks", tick_cnt, 8);
        cyc(1'b1, 1'b1, 1'b1, 8'h00); // commit uses staged 0x40 -> 0x4000
        run(64);
        check("R2 simultaneous strobes commit old stage", tick_cnt, 16);

        // R6: power of two duty
        tag = "R6"; load(16'h0800, 1'b0);
        run(256);
        check("R6 50% duty for 0x0800", high_cnt, 128);
        load(16'h8000, 1'b0);
        run(64);
        check("R6 50% duty for 0x8000", high_cnt, 32);
        check("R5 ticks every other cycle for 0x8000", tick_cnt, 32);

        // R3: negative words
        tag = "R3"; load(16'hE000, 1'b0);
        run(64);
        check("R3 0xE000 matches 0x2000 rate", tick_cnt, 8);
        load(16'hFFFF, 1'b0);
        run(200);
        check("R3 0xFFFF is slowest step", tick_cnt, 0);

        // R8: tick rate
        tag = "R8"; load(16'h0400, 1'b0);
        run(256);
        check("R8 tick count 0x0400", tick_cnt, 256 * 16'h0400 / 65536);
        load(16'h0030, 1'b0);
        run(4096);
        check("R8 tick count 0x0030", tick_cnt, 4096 * 16'h0030 / 65536);

        // R7: halt mid-run
        tag = "R7"; load(16'h1000, 1'b0);
        run(10);
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        check("R7 level low after halt", {31'd0, level_out}, 32'd0);
        run(16);
        check("R7 resume from phase 0", tick_cnt, 1);

        // R4/R5: random mix
        tag = "R4";
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [15:0] w;
            r = $urandom_range(0, 99);
            w = pool[$urandom_range(0, 7)];
            if (r < 3) cyc(1'b0, 1'b0, 1'b0, 8'h00);
            else if (r < 5) cyc(1'b1, 1'b1, 1'b0, w[15:8]);
            else if (r < 7) cyc(1'b1, 1'b0, 1'b1, w[7:0]);
            else if (r < 8) cyc(1'b1, 1'b1, 1'b1, 8'($urandom));
            else cyc(1'b1, 1'b0, 1'b0, 8'h00);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule